// File: doc/BRIEF.md
# Multi-core power state controller

This block sequences power for a small cluster of processor cores. One command arrives at a time on the request port: power on at an entry address, power on with a plain reset, power off, or warm reset. Every command names a core by its affinity ID. A power-on at an entry address also carries a context value, a target exception level and a 64-bit execution flag. The block checks the command against the power state and capability straps of the addressed core. It returns a result code one cycle after the request.

The block records an accepted power-on at once by moving the core to a pending state. The power-on completes a fixed number of cycles later. On completion the block pulses the core's reset, releases halt, loads the start address and boot register 0, and marks the core on. Power-off and warm reset take effect in the cycle the result appears. While a core is pending, a second power-on gets a distinct on-pending result, so two requesters that race to start the same core are resolved.

Top module: `pwr_core_ctl`

## Requirements
- R1: After reset every core is OFF (state code 0), `halt_o` is high, `core_rst_o` is low, start address and boot register 0 are zero, and `rsp_valid_o` is low.
- R2: A request sampled with `req_valid_i` high at a clock edge gives `rsp_valid_o` high for exactly the following cycle, with `rsp_code_o` set to 0 success, 1 invalid-parameter, 2 already-on, 3 on-pending or 4 is-off. With no request, `rsp_valid_o` is low.
- R3: Core i has affinity ID `AFF_BASE`+i. A request with any other ID returns 1 and changes no core.
- R4: Opcodes are 0 on-with-entry, 1 on-with-reset, 2 off, 3 warm reset. An on-with-entry request returns 1 in two cases: the level is 0, or the 64-bit flag is set and the entry address has a nonzero value in bits [1:0]. These checks come before any state check. When the 64-bit flag is clear, the block does not check the alignment of the entry address.
- R5: An on-with-entry request to a core that is not ON returns 1 in three cases: level 3 without the level-3 strap, level 2 without the level-2 strap, or a 32-bit request to a core whose 64-bit strap is set.
- R6: An on request (either kind) to an ON core returns 2, even when the capability checks would also fail.
- R7: An on request (either kind) to a core in ON_PENDING returns 3 and leaves the pending power-on untouched.
- R8: An accepted on request moves the core to ON_PENDING (state code 1) in the cycle its response appears. The core stays halted until the power-on completes, at the clock edge `DEFER_CYC` edges after the accepting edge.
- R9: On completion of an on-with-entry, `core_rst_o` pulses high for one cycle. In that same cycle `halt_o` goes low, the start address equals the entry, boot register 0 equals the context value, and the state becomes ON (code 2).
- R10: Completion of an on-with-reset pulses reset, releases halt and marks the core ON, leaving start address and boot register 0 at their previous values.
- R11: Power-off to an OFF core returns 4. Otherwise it returns 0, and in the response cycle the core is OFF with `halt_o` high. A pending power-on is cancelled.
- R12: Warm reset to an OFF core returns 4. Otherwise it returns 0 and pulses `core_rst_o` for the response cycle only, leaving the power state and halt unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe, one command per cycle |
| req_op_i | input | 2 | Command opcode |
| req_aff_i | input | AFF_W | Target core affinity ID |
| req_entry_i | input | ADDR_W | Entry address for on-with-entry |
| req_ctx_i | input | CTX_W | Context value for boot register 0 |
| req_el_i | input | 2 | Target exception level |
| req_aa64_i | input | 1 | 64-bit execution flag |
| cap_el2_i | input | NUM_CORES | Per-core level-2 capability strap |
| cap_el3_i | input | NUM_CORES | Per-core level-3 capability strap |
| cap_aa64_i | input | NUM_CORES | Per-core 64-bit capability strap |
| rsp_valid_o | output | 1 | Result valid |
| rsp_code_o | output | 3 | Result code |
| pwr_state_o | output | 2*NUM_CORES | Per-core power state, 2 bits each |
| halt_o | output | NUM_CORES | Per-core halt |
| core_rst_o | output | NUM_CORES | Per-core reset pulse |
| start_pc_o | output | ADDR_W*NUM_CORES | Per-core start address |
| boot_r0_o | output | CTX_W*NUM_CORES | Per-core boot register 0 |

## Verification
The assertions check on every cycle that a response follows each request by one cycle and has a legal code. They check that no core leaves the three state codes, that a core goes from OFF to ON only through the pending state, that OFF implies halt, and that malformed or unknown-ID requests come back invalid. Only the bench's scenarios can show the rest: the priority among the capability, already-on and on-pending checks, the exact completion cycle, and the values loaded into the start address and boot register. They also show that a plain reset keeps those values, that an off request cancels a pending power-on, and that a warm-reset pulse leaves the power state alone.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
  typedef enum logic [1:0] {PS_OFF = 2'd0, PS_PEND = 2'd1, PS_ON = 2'd2} pwr_state_e;
  typedef enum logic [1:0] {OP_ON_ENTRY = 2'd0, OP_ON_RESET = 2'd1, OP_OFF = 2'd2, OP_WARM = 2'd3} pwr_op_e;
  typedef enum logic [2:0] {
    RC_OK = 3'd0, RC_INVAL = 3'd1, RC_ALREADY_ON = 3'd2, RC_ON_PEND = 3'd3, RC_IS_OFF = 3'd4
  } pwr_rc_e;
endpackage

// File: rtl/pwr_req_check.sv
module pwr_req_check
  import pwr_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int AFF_W     = 8,
  parameter int AFF_BASE  = 16,
  localparam int IDX_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic [1:0]             op_i,
  input  logic [AFF_W-1:0]       aff_i,
  input  logic [1:0]             entry_lsb_i,
  input  logic [1:0]             el_i,
  input  logic                   aa64_i,
  input  logic [2*NUM_CORES-1:0] state_i,
  input  logic [NUM_CORES-1:0]   cap_el2_i,
  input  logic [NUM_CORES-1:0]   cap_el3_i,
  input  logic [NUM_CORES-1:0]   cap_aa64_i,
  output logic [IDX_W-1:0]       idx_o,
  output logic [2:0]             code_o,
  output logic                   go_on_o,
  output logic                   go_off_o,
  output logic                   go_warm_o
);
  logic       hit;
  logic [1:0] st;
  logic       cap_bad;

  always_comb begin
    hit   = 1'b0;
    idx_o = '0;
    for (int i = 0; i < NUM_CORES; i++) begin
      if (aff_i == AFF_W'(AFF_BASE + i)) begin
        hit   = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end

  assign st      = state_i[2*idx_o +: 2];
  assign cap_bad = (el_i == 2'd3 && !cap_el3_i[idx_o]) ||
                   (el_i == 2'd2 && !cap_el2_i[idx_o]) ||
                   (!aa64_i && cap_aa64_i[idx_o]);

  always_comb begin
    code_o    = RC_OK;
    go_on_o   = 1'b0;
    go_off_o  = 1'b0;
    go_warm_o = 1'b0;
    if (!hit) begin
      code_o = RC_INVAL;
    end else begin
      unique case (pwr_op_e'(op_i))
        OP_ON_ENTRY: begin
          if (el_i == 2'd0 || (aa64_i && entry_lsb_i != 2'b00)) code_o = RC_INVAL;
          else if (st == PS_ON)                                   code_o = RC_ALREADY_ON;
          else if (cap_bad)                                       code_o = RC_INVAL;
          else if (st == PS_PEND)                                 code_o = RC_ON_PEND;
          else                                                    go_on_o = 1'b1;
        end
        OP_ON_RESET: begin
          if (st == PS_ON)        code_o = RC_ALREADY_ON;
          else if (st == PS_PEND) code_o = RC_ON_PEND;
          else                    go_on_o = 1'b1;
        end
        OP_OFF: begin
          if (st == PS_OFF) code_o = RC_IS_OFF;
          else              go_off_o = 1'b1;
        end
        default: begin
          if (st == PS_OFF) code_o = RC_IS_OFF;
          else              go_warm_o = 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/pwr_core_slot.sv
module pwr_core_slot
  import pwr_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int CTX_W     = 32,
  parameter int DEFER_CYC = 4,
  localparam int CNT_W    = $clog2(DEFER_CYC + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_on_i,
  input  logic              with_entry_i,
  input  logic [ADDR_W-1:0] entry_i,
  input  logic [CTX_W-1:0]  ctx_i,
  input  logic              do_off_i,
  input  logic              do_warm_i,
  output logic [1:0]        state_o,
  output logic              halt_o,
  output logic              rst_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic [CTX_W-1:0]  r0_o
);
  pwr_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              kind_q;
  logic [ADDR_W-1:0] entry_q;
  logic [CTX_W-1:0]  ctx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PS_OFF;
      cnt_q   <= '0;
      kind_q  <= 1'b0;
      entry_q <= '0;
      ctx_q   <= '0;
      halt_o  <= 1'b1;
      rst_o   <= 1'b0;
      pc_o    <= '0;
      r0_o    <= '0;
    end else begin
      rst_o <= 1'b0;
      if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CNT_W'(1)) begin
        state_q <= PS_ON;
        halt_o  <= 1'b0;
        rst_o   <= 1'b1;
        if (kind_q) begin
          pc_o <= entry_q;
          r0_o <= ctx_q;
        end
      end
      if (start_on_i) begin
        state_q <= PS_PEND;
        cnt_q   <= CNT_W'(DEFER_CYC);
        kind_q  <= with_entry_i;
        entry_q <= entry_i;
        ctx_q   <= ctx_i;
      end
      if (do_warm_i) rst_o <= 1'b1;
      // off wins over a completion landing in the same cycle
      if (do_off_i) begin
        state_q <= PS_OFF;
        halt_o  <= 1'b1;
        cnt_q   <= '0;
      end
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/pwr_core_ctl.sv
module pwr_core_ctl
  import pwr_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = 32,
  parameter int CTX_W     = 32,
  parameter int AFF_W     = 8,
  parameter int AFF_BASE  = 16,
  parameter int DEFER_CYC = 4
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        req_valid_i,
  input  logic [1:0]                  req_op_i,
  input  logic [AFF_W-1:0]            req_aff_i,
  input  logic [ADDR_W-1:0]           req_entry_i,
  input  logic [CTX_W-1:0]            req_ctx_i,
  input  logic [1:0]                  req_el_i,
  input  logic                        req_aa64_i,
  input  logic [NUM_CORES-1:0]        cap_el2_i,
  input  logic [NUM_CORES-1:0]        cap_el3_i,
  input  logic [NUM_CORES-1:0]        cap_aa64_i,
  output logic                        rsp_valid_o,
  output logic [2:0]                  rsp_code_o,
  output logic [2*NUM_CORES-1:0]      pwr_state_o,
  output logic [NUM_CORES-1:0]        halt_o,
  output logic [NUM_CORES-1:0]        core_rst_o,
  output logic [ADDR_W*NUM_CORES-1:0] start_pc_o,
  output logic [CTX_W*NUM_CORES-1:0]  boot_r0_o
);
  localparam int IDX_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;

  logic [IDX_W-1:0] idx;
  logic [2:0]       code;
  logic             go_on, go_off, go_warm;

  pwr_req_check #(
    .NUM_CORES(NUM_CORES), .AFF_W(AFF_W), .AFF_BASE(AFF_BASE)
  ) u_check (
    .op_i       (req_op_i),
    .aff_i      (req_aff_i),
    .entry_lsb_i(req_entry_i[1:0]),
    .el_i       (req_el_i),
    .aa64_i     (req_aa64_i),
    .state_i    (pwr_state_o),
    .cap_el2_i  (cap_el2_i),
    .cap_el3_i  (cap_el3_i),
    .cap_aa64_i (cap_aa64_i),
    .idx_o      (idx),
    .code_o     (code),
    .go_on_o    (go_on),
    .go_off_o   (go_off),
    .go_warm_o  (go_warm)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_code_o  <= RC_OK;
    end else begin
      rsp_valid_o <= req_valid_i;
      if (req_valid_i) rsp_code_o <= code;
    end
  end

  for (genvar g = 0; g < NUM_CORES; g++) begin : g_core
    logic sel;
    assign sel = req_valid_i && (idx == IDX_W'(g));

    pwr_core_slot #(
      .ADDR_W(ADDR_W), .CTX_W(CTX_W), .DEFER_CYC(DEFER_CYC)
    ) u_slot (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .start_on_i  (sel && go_on),
      .with_entry_i(req_op_i == OP_ON_ENTRY),
      .entry_i     (req_entry_i),
      .ctx_i       (req_ctx_i),
      .do_off_i    (sel && go_off),
      .do_warm_i   (sel && go_warm),
      .state_o     (pwr_state_o[2*g +: 2]),
      .halt_o      (halt_o[g]),
      .rst_o       (core_rst_o[g]),
      .pc_o        (start_pc_o[ADDR_W*g +: ADDR_W]),
      .r0_o        (boot_r0_o[CTX_W*g +: CTX_W])
    );
  end
endmodule

// File: rtl/pwr_core_ctl_chk.sv
module pwr_core_ctl_chk
  import pwr_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = 32,
  parameter int AFF_W     = 8,
  parameter int AFF_BASE  = 16
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   req_valid_i,
  input logic [1:0]             req_op_i,
  input logic [AFF_W-1:0]       req_aff_i,
  input logic [ADDR_W-1:0]      req_entry_i,
  input logic [1:0]             req_el_i,
  input logic                   req_aa64_i,
  input logic                   rsp_valid_o,
  input logic [2:0]             rsp_code_o,
  input logic [2*NUM_CORES-1:0] pwr_state_o,
  input logic [NUM_CORES-1:0]   halt_o
);
  logic aff_miss;
  assign aff_miss = ({1'b0, req_aff_i} < (AFF_W+1)'(AFF_BASE)) ||
                    ({1'b0, req_aff_i} >= (AFF_W+1)'(AFF_BASE + NUM_CORES));

  a_r2_rsp_follows_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);
  a_r2_no_spurious_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);
  a_r2_legal_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> rsp_code_o <= RC_IS_OFF);
  a_r3_unknown_id: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && aff_miss) |=> rsp_code_o == RC_INVAL);
  a_r4_bad_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_op_i == OP_ON_ENTRY && req_el_i == 2'd0) |=> rsp_code_o == RC_INVAL);
  a_r4_misaligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_op_i == OP_ON_ENTRY && req_aa64_i && req_entry_i[1:0] != 2'b00)
    |=> rsp_code_o == RC_INVAL);

  for (genvar g = 0; g < NUM_CORES; g++) begin : g_core
    a_r8_state_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pwr_state_o[2*g +: 2] != 2'd3);
    a_r8_on_via_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pwr_state_o[2*g +: 2] == PS_OFF |=> pwr_state_o[2*g +: 2] != PS_ON);
    a_r11_off_halted: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pwr_state_o[2*g +: 2] != PS_ON |-> halt_o[g]);
  end
endmodule

bind pwr_core_ctl pwr_core_ctl_chk #(
  .NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W), .AFF_W(AFF_W), .AFF_BASE(AFF_BASE)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_op_i(req_op_i),
  .req_aff_i(req_aff_i), .req_entry_i(req_entry_i), .req_el_i(req_el_i),
  .req_aa64_i(req_aa64_i), .rsp_valid_o(rsp_valid_o), .rsp_code_o(rsp_code_o),
  .pwr_state_o(pwr_state_o), .halt_o(halt_o)
);

// File: tb/sim_pwr_core_ctl.sv
module sim_pwr_core_ctl;
  localparam int N = 4;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_valid_i = 1'b0;
  logic [1:0]    req_op_i = '0;
  logic [7:0]    req_aff_i = '0;
  logic [31:0]   req_entry_i = '0;
  logic [31:0]   req_ctx_i = '0;
  logic [1:0]    req_el_i = '0;
  logic          req_aa64_i = 1'b0;
  logic [N-1:0]  cap_el2_i  = 4'b0111;
  logic [N-1:0]  cap_el3_i  = 4'b0001;
  logic [N-1:0]  cap_aa64_i = 4'b1011;
  logic          rsp_valid_o;
  logic [2:0]    rsp_code_o;
  logic [2*N-1:0] pwr_state_o;
  logic [N-1:0]  halt_o, core_rst_o;
  logic [32*N-1:0] start_pc_o, boot_r0_o;

  int n_chk = 0, n_fail = 0;

  always #10 clk_i = ~clk_i;

  pwr_core_ctl u0 (.*);

  // {op, aff, el, aa64, entry, ctx, expected code}
  localparam int NV = 17;
  localparam logic [79:0] VEC [NV] = '{
    {2'd0, 8'h05, 2'd1, 1'b1, 32'h0000_1000, 32'h0, 3'd1},  // R3
    {2'd0, 8'h10, 2'd0, 1'b1, 32'h0000_1000, 32'h0, 3'd1},  // R4 level 0
    {2'd0, 8'h10, 2'd1, 1'b1, 32'h0000_1002, 32'h0, 3'd1},  // R4 misaligned
    {2'd0, 8'h11, 2'd3, 1'b1, 32'h0000_1000, 32'h0, 3'd1},  // R5 no level 3
    {2'd0, 8'h13, 2'd2, 1'b1, 32'h0000_1000, 32'h0, 3'd1},  // R5 no level 2
    {2'd0, 8'h10, 2'd2, 1'b0, 32'h0000_1000, 32'h0, 3'd1},  // R5 32-bit on 64-bit core
    {2'd2, 8'h10, 2'd0, 1'b0, 32'h0,         32'h0, 3'd4},  // R11 off when off
    {2'd3, 8'h10, 2'd0, 1'b0, 32'h0,         32'h0, 3'd4},  // R12 warm when off
    {2'd0, 8'h10, 2'd3, 1'b1, 32'h8000_1000, 32'h0000_cafe, 3'd0},  // R8
    {2'd0, 8'h10, 2'd1, 1'b1, 32'h0000_2000, 32'h0, 3'd2},  // R6
    {2'd1, 8'h10, 2'd0, 1'b0, 32'h0,         32'h0, 3'd2},  // R6 plain
    {2'd0, 8'h12, 2'd1, 1'b0, 32'h0000_2002, 32'h0000_0022, 3'd0},  // R4 no align in 32-bit
    {2'd1, 8'h11, 2'd0, 1'b0, 32'h0,         32'h0, 3'd0},  // R10
    {2'd2, 8'h11, 2'd0, 1'b0, 32'h0,         32'h0, 3'd0},  // R11
    {2'd3, 8'h10, 2'd0, 1'b0, 32'h0,         32'h0, 3'd0},  // R12
    {2'd0, 8'h13, 2'd1, 1'b1, 32'h0000_0040, 32'h0000_0033, 3'd0},  // R8
    {2'd0, 8'h13, 2'd3, 1'b1, 32'h0000_0080, 32'h0, 3'd2}   // R6 beats capability
  };

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // drive at negedge; returns at the negedge after the sampling edge
  task automatic do_req(input logic [1:0] op, input logic [7:0] aff, input logic [1:0] el,
                        input logic aa64, input logic [31:0] entry, input logic [31:0] ctx);
    @(negedge clk_i);
    req_valid_i = 1'b1; req_op_i = op; req_aff_i = aff; req_el_i = el;
    req_aa64_i = aa64; req_entry_i = entry; req_ctx_i = ctx;
    @(negedge clk_i);
    req_valid_i = 1'b0;
  endtask

  function automatic logic [1:0] st(input int c);
    return pwr_state_o[2*c +: 2];
  endfunction

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(pwr_state_o, '0, "R1 states");
    chk(halt_o, 4'hf, "R1 halt");
    chk(core_rst_o, '0, "R1 core reset");
    chk(start_pc_o[63:0] | start_pc_o[127:64], '0, "R1 start address");
    chk(boot_r0_o[63:0] | boot_r0_o[127:64], '0, "R1 boot register");
    chk(rsp_valid_o, 0, "R1 no response");

    for (int v = 0; v < NV; v++) begin
      do_req(VEC[v][79:78], VEC[v][77:70], VEC[v][69:68], VEC[v][67],
             VEC[v][66:35], VEC[v][34:3]);
      chk(rsp_valid_o, 1, $sformatf("R2 valid vec %0d", v));
      chk(rsp_code_o, VEC[v][2:0], $sformatf("R2 code vec %0d", v));
      repeat (6) @(negedge clk_i);
    end
    chk(rsp_valid_o, 0, "R2 idle");
    chk(st(0), 2, "R8 core0 on");
    chk(halt_o[0], 0, "R9 core0 halt");
    chk(start_pc_o[31:0], 32'h8000_1000, "R9 core0 pc");
    chk(boot_r0_o[31:0], 32'h0000_cafe, "R9 core0 r0");
    chk(st(1), 0, "R11 core1 off");
    chk(halt_o[1], 1, "R11 core1 halt");
    chk(start_pc_o[63:32], 0, "R3 R5 core1 pc untouched");
    chk(start_pc_o[95:64], 32'h0000_2002, "R9 core2 pc");
    chk(boot_r0_o[95:64], 32'h22, "R9 core2 r0");
    chk(start_pc_o[127:96], 32'h40, "R6 core3 pc kept");

    // R7 race and R8 exact completion cycle
    do_req(2'd0, 8'h11, 2'd1, 1'b1, 32'h100, 32'h11);
    chk(rsp_code_o, 0, "R8 accept");
    chk(st(1), 1, "R8 pending");
    chk(halt_o[1], 1, "R8 halted while pending");
    do_req(2'd1, 8'h11, 2'd0, 1'b0, 32'h0, 32'h0);
    chk(rsp_code_o, 3, "R7 on-pending");
    @(negedge clk_i);
    chk(st(1), 1, "R8 still pending");
    chk(core_rst_o[1], 0, "R9 no early reset");
    @(negedge clk_i);
    chk(st(1), 2, "R9 on at completion");
    chk(core_rst_o[1], 1, "R9 reset pulse");
    chk(halt_o[1], 0, "R9 halt released");
    chk(start_pc_o[63:32], 32'h100, "R9 pc");
    chk(boot_r0_o[63:32], 32'h11, "R9 r0");
    @(negedge clk_i);
    chk(core_rst_o[1], 0, "R9 pulse one cycle");

    // R10 plain on keeps address and boot register
    do_req(2'd2, 8'h11, 2'd0, 1'b0, 32'h0, 32'h0);
    chk(st(1), 0, "R11 off");
    do_req(2'd1, 8'h11, 2'd0, 1'b0, 32'h0, 32'hffff);
    repeat (6) @(negedge clk_i);
    chk(st(1), 2, "R10 on");
    chk(halt_o[1], 0, "R10 halt");
    chk(start_pc_o[63:32], 32'h100, "R10 pc kept");
    chk(boot_r0_o[63:32], 32'h11, "R10 r0 kept");

    // R11 off cancels pending power-on
    do_req(2'd2, 8'h11, 2'd0, 1'b0, 32'h0, 32'h0);
    do_req(2'd0, 8'h11, 2'd1, 1'b1, 32'h200, 32'h55);
    do_req(2'd2, 8'h11, 2'd0, 1'b0, 32'h0, 32'h0);
    chk(rsp_code_o, 0, "R11 off pending");
    chk(st(1), 0, "R11 off now");
    repeat (6) @(negedge clk_i);
    chk(st(1), 0, "R11 cancelled");
    chk(halt_o[1], 1, "R11 stays halted");
    chk(start_pc_o[63:32], 32'h100, "R11 pc not loaded");

    // R12 warm reset on an ON core
    do_req(2'd3, 8'h10, 2'd0, 1'b0, 32'h0, 32'h0);
    chk(rsp_code_o, 0, "R12 accept");
    chk(core_rst_o[0], 1, "R12 pulse");
    chk(st(0), 2, "R12 state kept");
    chk(halt_o[0], 0, "R12 halt kept");
    @(negedge clk_i);
    chk(core_rst_o[0], 0, "R12 pulse ends");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule